// File: doc/BRIEF.md
# Partitioned Test Window Sequencer

The block schedules the tests of several cores that share one test bus. Each core gets a compact scheme: a start time, a window count, a first-window length, a nominal window length, a total test length, a cooling span and a switching overhead. From that scheme a per-core sequencer plays out a timed series of test windows: one long opening window, identical middle windows and a shortened closing window. Consecutive windows are separated by a cooling span, then a switching overhead. All cores run off one shared cycle counter, so the schedule is fixed by arithmetic and needs no per-window storage.

Software loads each core's scheme through a simple write port while the block is idle. A start pulse clears the shared time base and arms every sequencer. During a window the core's test strobe is high. During the cooling span both strobes are low. During the switching overhead only the bus-request strobe is high. A small checker adds up the wire widths of all cores that request the bus in a cycle. It raises a sticky flag, and records the time of the first cycle whose sum exceeds the bus width, without stopping any core.

Top module: `pts_window_ctrl`

## Requirements
- R1: After reset, every strobe, done flag, partition index, `all_done`, `bw_viol` and `bw_viol_time` is zero.
- R2: The cycle after the start pulse is accepted has time 0. A core's first window begins in the cycle whose time equals its programmed start time.
- R3: With a window count of 1 (0 is treated as 1), the core runs one window of exactly the total length, with no gap.
- R4: With a count m of 2 or more, window 0 lasts the first-window length and windows 1 to m-2 each last the nominal length.
- R5: After each non-final window, `test_active` and `bus_req` are both low for the cooling span. Then, for the switching overhead, `bus_req` is high and `test_active` is low. The next window begins right after. A span of zero inserts no cycles.
- R6: The final window lasts total − first − (m−2)·nominal, taken as zero if negative. When that length is zero, the test ends after window m−2 with no further gap.
- R7: `part_idx` of each core (bits [PW·c+PW-1:PW·c]) gives the 0-based index of the current window. It holds its value through cooling and switching cycles, and keeps the final index after completion.
- R8: A core's done flag rises in the cycle after its last window cycle and stays high until the next accepted start. `all_done` is high when every core is done.
- R9: Configuration writes and start pulses arriving while a run is in progress have no effect on the current run or on the stored configuration.
- R10: `bw_viol` goes high in the cycle after the first cycle in which the summed widths of requesting cores exceed BUS_W. It stays high until the next start. `bw_viol_time` holds the time of that first cycle, and the windows are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when no run is in progress |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | SELW | Core selected for the write |
| cfg_start | input | TW | Window 0 start time |
| cfg_parts | input | PW | Window count m |
| cfg_first | input | TW | First-window length |
| cfg_nom | input | TW | Nominal window length |
| cfg_total | input | TW | Total test length |
| cfg_cool | input | TW | Cooling span |
| cfg_ovh | input | TW | Switching overhead |
| cfg_width | input | WW | Bus wires held by the core |
| test_active | output | NCORE | Per-core window strobe |
| bus_req | output | NCORE | Per-core bus request (window or switching) |
| part_idx | output | NCORE·PW | Per-core current window index |
| done | output | NCORE | Per-core completion flag |
| all_done | output | 1 | All cores complete |
| bw_viol | output | 1 | Sticky bus over-subscription flag |
| bw_viol_time | output | TW | Time of first over-subscription |

## Verification
The interesting coincidence is a bus over-subscription that lands in the same cycle as a window boundary or a switching overhead of another core. The checker must flag that cycle while both sequencers keep their exact timing. The bench staggers two cores so that the switching cycles of one overlap the window of the other, with widths summing above the bus width. It then compares every cycle of both cores against a schedule computed from the requirements, and compares the recorded violation time against the first cycle in which its own width sum exceeds the limit. A second coincidence, a configuration write together with a start pulse in the middle of a run, is judged by an unchanged schedule in that run and in the run after it.

// File: rtl/pts_pkg.sv
// Shared types for the partitioned test window sequencer.
package pts_pkg;
    // Phase of one core's test schedule.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACT,
        ST_COOL,
        ST_SW,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/pts_cfg_bank.sv
// Holds each core's partitioning scheme.
// Assumes: lock is high for as long as a run is in progress; a write to a
// core index at or above NCORE is dropped.
module pts_cfg_bank #(
    parameter int NCORE = 2,
    parameter int TW    = 16,
    parameter int PW    = 4,
    parameter int WW    = 4,
    parameter int SELW  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lock,
    input  logic                        we,
    input  logic [SELW-1:0]             sel,
    input  logic [TW-1:0]               w_start,
    input  logic [PW-1:0]               w_parts,
    input  logic [TW-1:0]               w_first,
    input  logic [TW-1:0]               w_nom,
    input  logic [TW-1:0]               w_total,
    input  logic [TW-1:0]               w_cool,
    input  logic [TW-1:0]               w_ovh,
    input  logic [WW-1:0]               w_width,
    output logic [NCORE-1:0][TW-1:0]    q_start,
    output logic [NCORE-1:0][PW-1:0]    q_parts,
    output logic [NCORE-1:0][TW-1:0]    q_first,
    output logic [NCORE-1:0][TW-1:0]    q_nom,
    output logic [NCORE-1:0][TW-1:0]    q_total,
    output logic [NCORE-1:0][TW-1:0]    q_cool,
    output logic [NCORE-1:0][TW-1:0]    q_ovh,
    output logic [NCORE-1:0][WW-1:0]    q_width
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic hit;
        assign hit = we && !lock && (sel == SELW'(c));

        // Load this core's scheme on an unlocked write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_start[c] <= '0;
                q_parts[c] <= PW'(1);
                q_first[c] <= TW'(1);
                q_nom[c]   <= TW'(1);
                q_total[c] <= TW'(1);
                q_cool[c]  <= '0;
                q_ovh[c]   <= '0;
                q_width[c] <= '0;
            end else if (hit) begin
                q_start[c] <= w_start;
                q_parts[c] <= w_parts;
                q_first[c] <= w_first;
                q_nom[c]   <= w_nom;
                q_total[c] <= w_total;
                q_cool[c]  <= w_cool;
                q_ovh[c]   <= w_ovh;
                q_width[c] <= w_width;
            end
        end

        // R9
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> $stable({q_start[c], q_parts[c], q_first[c], q_nom[c],
                              q_total[c], q_cool[c], q_ovh[c], q_width[c]}));
    end
endmodule

// File: rtl/pts_core_seq.sv
// Plays out one core's partitioned test: optional wait, then windows
// separated by a cooling span and a switching overhead.
// Assumes: the scheme is stable while running; first, nominal and total
// lengths are at least 1; arm only pulses when no run is in progress.
module pts_core_seq
    import pts_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [TW-1:0] start_t,
    input  logic [PW-1:0] parts,
    input  logic [TW-1:0] first_len,
    input  logic [TW-1:0] nom_len,
    input  logic [TW-1:0] total_len,
    input  logic [TW-1:0] cool_len,
    input  logic [TW-1:0] ovh_len,
    output logic          test_active,
    output logic          bus_req,
    output logic [PW-1:0] part_idx,
    output logic          done
);
    localparam int XW = TW + PW + 1;

    seq_state_t    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] idx_q, idx_d;

    logic [PW-1:0] m_eff, mid_cnt, nxt_idx;
    logic [XW-1:0] used_len;
    logic [TW-1:0] last_len, len_first, len_nxt;
    logic          final_end;

    // Derive the window count and the closing window length.
    always_comb begin
        m_eff     = (parts == '0) ? PW'(1) : parts;
        mid_cnt   = (m_eff >= PW'(2)) ? (m_eff - PW'(2)) : '0;
        used_len  = XW'(first_len) + XW'(mid_cnt) * XW'(nom_len);
        last_len  = (XW'(total_len) > used_len) ? TW'(XW'(total_len) - used_len) : '0;
        len_first = (m_eff == PW'(1)) ? total_len : first_len;
        nxt_idx   = idx_q + PW'(1);
        len_nxt   = (nxt_idx == m_eff - PW'(1)) ? last_len : nom_len;
        final_end = (idx_q == m_eff - PW'(1)) ||
                    ((nxt_idx == m_eff - PW'(1)) && (last_len == '0));
    end

    // Next phase, countdown and window index.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        if (arm) begin
            idx_d = '0;
            if (start_t == '0) begin
                state_d = ST_ACT;
                cnt_d   = len_first - TW'(1);
            end else begin
                state_d = ST_WAIT;
                cnt_d   = start_t - TW'(1);
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end else begin
            case (state_q)
                ST_WAIT: begin
                    state_d = ST_ACT;
                    cnt_d   = len_first - TW'(1);
                end
                ST_ACT: begin
                    if (final_end) begin
                        state_d = ST_DONE;
                    end else if (cool_len != '0) begin
                        state_d = ST_COOL;
                        cnt_d   = cool_len - TW'(1);
                    end else if (ovh_len != '0) begin
                        state_d = ST_SW;
                        cnt_d   = ovh_len - TW'(1);
                    end else begin
                        idx_d   = nxt_idx;
                        cnt_d   = len_nxt - TW'(1);
                    end
                end
                ST_COOL: begin
                    if (ovh_len != '0) begin
                        state_d = ST_SW;
                        cnt_d   = ovh_len - TW'(1);
                    end else begin
                        state_d = ST_ACT;
                        idx_d   = nxt_idx;
                        cnt_d   = len_nxt - TW'(1);
                    end
                end
                ST_SW: begin
                    state_d = ST_ACT;
                    idx_d   = nxt_idx;
                    cnt_d   = len_nxt - TW'(1);
                end
                default: ;
            endcase
        end
    end

    // Register the schedule state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    assign test_active = (state_q == ST_ACT);
    assign bus_req     = (state_q == ST_ACT) || (state_q == ST_SW);
    assign done        = (state_q == ST_DONE);
    assign part_idx    = idx_q;

    // R5
    act_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_active |-> bus_req);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm |=> done);

    // R7
    idx_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SW) |-> (part_idx == $past(part_idx)));

    // R2
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm && (start_t == '0) |=> test_active && (part_idx == '0));
endmodule

// File: rtl/pts_bw_check.sv
// Sums the wire widths of requesting cores and records the first cycle
// whose sum exceeds the bus width. Observes only; never gates a core.
// Assumes: clr pulses when a new run is armed.
module pts_bw_check #(
    parameter int NCORE = 2,
    parameter int TW    = 16,
    parameter int WW    = 4,
    parameter int BUS_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [NCORE-1:0]         req,
    input  logic [NCORE-1:0][WW-1:0] width,
    input  logic [TW-1:0]            now,
    output logic                     viol,
    output logic [TW-1:0]            viol_time
);
    localparam int SW = WW + $clog2(NCORE + 1);

    logic [SW-1:0] sum;
    logic          over;

    // Add up the widths of every requesting core.
    always_comb begin
        sum = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (req[c]) sum = sum + SW'(width[c]);
        end
        over = (sum > SW'(BUS_W));
    end

    // Latch the first over-subscription until the next run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            viol      <= 1'b0;
            viol_time <= '0;
        end else if (over && !viol) begin
            viol      <= 1'b1;
            viol_time <= now;
        end
    end

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol && !clr |=> viol);

    // R10
    viol_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol && !clr |=> $stable(viol_time));
endmodule

// File: rtl/pts_window_ctrl.sv
// Top of the partitioned test window sequencer: shared time base, run
// control, configuration bank, one sequencer per core and bus checker.
// Assumes: start is a single-cycle pulse; all cores share the time base.
module pts_window_ctrl #(
    parameter int NCORE = 2,
    parameter int TW    = 16,
    parameter int PW    = 4,
    parameter int WW    = 4,
    parameter int BUS_W = 6,
    parameter int SELW  = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cfg_we,
    input  logic [SELW-1:0]     cfg_sel,
    input  logic [TW-1:0]       cfg_start,
    input  logic [PW-1:0]       cfg_parts,
    input  logic [TW-1:0]       cfg_first,
    input  logic [TW-1:0]       cfg_nom,
    input  logic [TW-1:0]       cfg_total,
    input  logic [TW-1:0]       cfg_cool,
    input  logic [TW-1:0]       cfg_ovh,
    input  logic [WW-1:0]       cfg_width,
    output logic [NCORE-1:0]    test_active,
    output logic [NCORE-1:0]    bus_req,
    output logic [NCORE*PW-1:0] part_idx,
    output logic [NCORE-1:0]    done,
    output logic                all_done,
    output logic                bw_viol,
    output logic [TW-1:0]       bw_viol_time
);
    logic          running_q;
    logic          arm;
    logic [TW-1:0] now_q;

    logic [NCORE-1:0][TW-1:0] c_start, c_first, c_nom, c_total, c_cool, c_ovh;
    logic [NCORE-1:0][PW-1:0] c_parts;
    logic [NCORE-1:0][WW-1:0] c_width;

    assign arm      = start && !running_q;
    assign all_done = &done;

    // Track whether a run is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)        running_q <= 1'b0;
        else if (arm)      running_q <= 1'b1;
        else if (all_done) running_q <= 1'b0;
    end

    // Shared time base: zero in the first cycle after arming.
    always_ff @(posedge clk) begin
        if (!rst_n)         now_q <= '0;
        else if (arm)       now_q <= '0;
        else if (running_q) now_q <= now_q + TW'(1);
    end

    pts_cfg_bank #(
        .NCORE(NCORE), .TW(TW), .PW(PW), .WW(WW), .SELW(SELW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .lock(running_q),
        .we(cfg_we), .sel(cfg_sel),
        .w_start(cfg_start), .w_parts(cfg_parts), .w_first(cfg_first),
        .w_nom(cfg_nom), .w_total(cfg_total), .w_cool(cfg_cool),
        .w_ovh(cfg_ovh), .w_width(cfg_width),
        .q_start(c_start), .q_parts(c_parts), .q_first(c_first),
        .q_nom(c_nom), .q_total(c_total), .q_cool(c_cool),
        .q_ovh(c_ovh), .q_width(c_width)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_seq
        pts_core_seq #(.TW(TW), .PW(PW)) u_seq (
            .clk(clk), .rst_n(rst_n), .arm(arm),
            .start_t(c_start[c]), .parts(c_parts[c]),
            .first_len(c_first[c]), .nom_len(c_nom[c]),
            .total_len(c_total[c]), .cool_len(c_cool[c]),
            .ovh_len(c_ovh[c]),
            .test_active(test_active[c]), .bus_req(bus_req[c]),
            .part_idx(part_idx[c*PW +: PW]), .done(done[c])
        );
    end

    pts_bw_check #(
        .NCORE(NCORE), .TW(TW), .WW(WW), .BUS_W(BUS_W)
    ) u_bw (
        .clk(clk), .rst_n(rst_n), .clr(arm),
        .req(bus_req), .width(c_width), .now(now_q),
        .viol(bw_viol), .viol_time(bw_viol_time)
    );

    // R8
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_done && !arm |=> !running_q);
endmodule

// File: tb/pts_window_ctrl_tb.sv
module pts_window_ctrl_tb;
    localparam int NC = 2;
    localparam int TW = 16;
    localparam int PW = 4;
    localparam int WW = 4;
    localparam int BW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_sel = '0;
    logic [TW-1:0] cfg_start = '0, cfg_first = '0, cfg_nom = '0;
    logic [TW-1:0] cfg_total = '0, cfg_cool = '0, cfg_ovh = '0;
    logic [PW-1:0] cfg_parts = '0;
    logic [WW-1:0] cfg_width = '0;
    logic [NC-1:0] test_active, bus_req, done;
    logic [NC*PW-1:0] part_idx;
    logic all_done, bw_viol;
    logic [TW-1:0] bw_viol_time;

    int checks = 0;
    int fails = 0;

    // bench copy of each core's scheme
    int e_s[NC], e_m[NC], e_f[NC], e_n[NC], e_t[NC], e_d[NC], e_o[NC], e_w[NC];

    always #10 clk = ~clk;

    pts_window_ctrl #(.NCORE(NC), .TW(TW), .PW(PW), .WW(WW), .BUS_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_start(cfg_start), .cfg_parts(cfg_parts),
        .cfg_first(cfg_first), .cfg_nom(cfg_nom), .cfg_total(cfg_total),
        .cfg_cool(cfg_cool), .cfg_ovh(cfg_ovh), .cfg_width(cfg_width),
        .test_active(test_active), .bus_req(bus_req), .part_idx(part_idx),
        .done(done), .all_done(all_done), .bw_viol(bw_viol),
        .bw_viol_time(bw_viol_time)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int c, input int s, input int m, input int f,
                             input int n, input int t, input int d, input int o,
                             input int w);
        cfg_sel = 1'(c); cfg_start = TW'(s); cfg_parts = PW'(m);
        cfg_first = TW'(f); cfg_nom = TW'(n); cfg_total = TW'(t);
        cfg_cool = TW'(d); cfg_ovh = TW'(o); cfg_width = WW'(w);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        e_s[c] = s; e_m[c] = (m == 0) ? 1 : m; e_f[c] = f; e_n[c] = n;
        e_t[c] = t; e_d[c] = d; e_o[c] = o; e_w[c] = w;
    endtask

    // Expected outputs of core c at time k, from R2..R8.
    // Encoding of the result: bit0 test_active, bit1 bus_req, bit2 done, bits[7:4] index.
    function automatic int expect_at(input int c, input int k);
        int t0, len, last, fin, idx;
        bit act, bus;
        t0 = e_s[c]; idx = 0; act = 0; bus = 0;
        last = e_t[c] - e_f[c] - (e_m[c] - 2) * e_n[c];
        if (last < 0) last = 0;
        fin = -1;
        for (int j = 0; j < e_m[c]; j++) begin
            if (e_m[c] == 1) len = e_t[c];
            else if (j == 0) len = e_f[c];
            else if (j == e_m[c] - 1) len = last;
            else len = e_n[c];
            if (j > 0 && j == e_m[c] - 1 && len == 0) break;
            if (k >= t0) idx = j;
            if (k >= t0 && k < t0 + len) act = 1;
            fin = t0 + len;
            if (j == e_m[c] - 1 || (j + 1 == e_m[c] - 1 && last == 0 && e_m[c] > 1)) break;
            if (k >= fin + e_d[c] && k < fin + e_d[c] + e_o[c]) bus = 1;
            t0 = fin + e_d[c] + e_o[c];
        end
        return int'(act) | (int'(act | bus) << 1) | (int'(k >= fin) << 2) | (idx << 4);
    endfunction

    // Arm a run and compare every cycle; optionally disturb at cycle dk.
    task automatic run_sched(input string req, input int ncyc, input int dk);
        int e, sum, vk;
        vk = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            sum = 0;
            for (int c = 0; c < NC; c++) begin
                e = expect_at(c, k);
                check({req, " active"}, int'(test_active[c]), e & 1);
                check({req, " bus_req"}, int'(bus_req[c]), (e >> 1) & 1);
                check({req, " done R8"}, int'(done[c]), (e >> 2) & 1);
                check({req, " idx R7"}, int'(part_idx[c*PW +: PW]), e >> 4);
                if (((e >> 1) & 1) != 0) sum += e_w[c];
            end
            if (sum > BW && vk < 0) vk = k;
            if (k == dk) begin
                // R9: write a different scheme and pulse start mid-run
                cfg_sel = 1'b0; cfg_start = '0; cfg_parts = PW'(1);
                cfg_total = TW'(2); cfg_cool = '0; cfg_ovh = '0;
                cfg_first = TW'(1); cfg_nom = TW'(1); cfg_width = WW'(7);
                cfg_we = 1'b1; start = 1'b1;
            end
            @(negedge clk);
            cfg_we = 1'b0; start = 1'b0;
        end
        check({req, " all_done R8"}, int'(all_done), 1);
        check({req, " viol R10"}, int'(bw_viol), int'(vk >= 0));
        check({req, " viol_time R10"}, int'(bw_viol_time), (vk >= 0) ? vk : 0);
    endtask

    task automatic t_reset;
        check("R1 active", int'(test_active), 0);
        check("R1 bus_req", int'(bus_req), 0);
        check("R1 done", int'(done), 0);
        check("R1 idx", int'(part_idx), 0);
        check("R1 all_done", int'(all_done), 0);
        check("R1 viol", int'(bw_viol), 0);
        check("R1 viol_time", int'(bw_viol_time), 0);
    endtask

    task automatic t_basic;   // R2 R3 R4
        write_cfg(0, 0, 1, 1, 1, 7, 0, 0, 2);
        write_cfg(1, 3, 3, 5, 3, 10, 2, 0, 3);
        run_sched("R2/R3/R4", 40, -1);
    endtask

    task automatic t_overlap;  // R5 R6 R10
        write_cfg(0, 1, 4, 6, 3, 14, 3, 2, 4);
        write_cfg(1, 2, 2, 4, 1, 9, 1, 1, 3);
        run_sched("R5/R6/R10", 60, -1);
    endtask

    task automatic t_zero_last;  // R6 saturation and exact zero
        write_cfg(0, 0, 3, 4, 2, 6, 2, 1, 1);
        write_cfg(1, 1, 2, 5, 1, 3, 1, 1, 1);
        run_sched("R6 zero-last", 30, -1);
    endtask

    task automatic t_back_to_back;  // R5 zero spans
        write_cfg(0, 2, 3, 3, 2, 7, 0, 0, 2);
        write_cfg(1, 0, 2, 2, 1, 5, 0, 3, 2);
        run_sched("R5 no-gap", 30, -1);
    endtask

    task automatic t_locked;  // R9
        run_sched("R9 mid-run", 30, 3);
        run_sched("R9 after", 30, -1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overlap();
        t_zero_last();
        t_back_to_back();
        t_locked();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule